// File: doc/BRIEF.md
# Codec GPIO Slot Register Interface

This block sits between a host register bus and the framing logic of a two-codec audio link. It holds one 32-bit register that gives the host access to the general-purpose I/O slot of the link. In the receive direction, at every frame boundary it copies the interrupt bit from the GPIO slot each codec returned, and it raises an interrupt when a captured bit is set and the matching enable is on.

In the transmit direction the host writes a 16-bit value and a send command in a single register write. The block then offers that value to the link serializer for exactly one outgoing frame. The command bit reads back as a busy flag, so the host polls it before it issues the next send. The serializer and the frame timing generator are outside this block. The framing logic supplies a one-cycle pulse on the last cycle of each frame, together with bit 0 of the GPIO slot received from each codec in that frame.

Top module: `codec_gpio_slot`

## Requirements
- R1: After reset the register reads 0, `gpioIrq` is 0, `txSlotValid` is 0 and `txSlotData` is 0.
- R2: On a cycle with `frameEnd` high, register bit 1 loads `rxGpioIntPri` and bit 2 loads `rxGpioIntSec`. The new values are readable on the next cycle. These bits hold their value between frame ends and ignore host writes.
- R3: Register bit 3 (primary enable) and bit 4 (secondary enable) are written from the write data and read back unchanged.
- R4: `gpioIrq` is 1 exactly when (bit 1 AND bit 3) OR (bit 2 AND bit 4) of the register are set.
- R5: A write with bit 15 = 1 while bit 15 reads 0 makes bit 15 read 1 from the next cycle.
- R6: Once set, bit 15 stays 1 through the rest of the current frame and through the whole following frame. `txSlotValid` is 1 during that following frame only. Both return to 0 on the cycle after the `frameEnd` that closes that frame.
- R7: While `txSlotValid` is 1, `txSlotData` equals register bits 31:16 as they stood on the cycle of the `frameEnd` that opened the sending frame. It does not change during the frame.
- R8: A write with bit 15 = 1 while bit 15 reads 1 does not start another send. The other writable fields of that write still take effect.
- R9: Bit 0 and bits 14:5 always read 0, whatever is written to them.
- R10: Register bits 31:16 are written from the write data on every write, busy or not, and read back unchanged.
- R11: A write with bit 15 = 0 leaves the send state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, always presented |
| frameEnd | input | 1 | One-cycle pulse on the last cycle of each link frame |
| rxGpioIntPri | input | 1 | Bit 0 of the GPIO slot received from the primary codec in this frame |
| rxGpioIntSec | input | 1 | Bit 0 of the GPIO slot received from the secondary codec in this frame |
| txSlotData | output | 16 | Value for the outgoing GPIO slot |
| txSlotValid | output | 1 | High during the frame whose GPIO slot carries `txSlotData` |
| gpioIrq | output | 1 | Maskable GPIO interrupt |

## Verification
The hardest cases to reach are the edges of the send sequence: a command that lands on the same cycle as a frame end, and a second command, carrying fresh data, issued in the pending wait or in the middle of the sending frame. The stimulus places writes at chosen offsets from the frame pulse, including on it and just after it. A behavioural model follows the send phase frame by frame and compares every output on every cycle. A counter of sending frames confirms that each accepted command produced exactly one.

// File: rtl/codec_gpio_pkg.sv
package codec_gpio_pkg;
  localparam int REG_W   = 32;
  localparam int GP_W    = 16;
  localparam int N_CODEC = 2;

  localparam int ST_LSB  = 1;   // captured interrupt bits 1..2
  localparam int EN_LSB  = 3;   // enables 3..4
  localparam int CMD_BIT = 15;  // command / busy
  localparam int DAT_LSB = 16;  // slot data 31..16

  typedef enum logic [1:0] {
    SND_IDLE = 2'd0,
    SND_PEND = 2'd1,
    SND_SEND = 2'd2
  } sendState_t;

  typedef struct packed {
    logic latchTx;
    logic sendActive;
    logic busy;
  } ctrlStrobe_t;
endpackage

// File: rtl/codec_gpio_ctrl.sv
module codec_gpio_ctrl
  import codec_gpio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        cmdBit,
  input  logic        frameEnd,
  output ctrlStrobe_t strobe
);
  sendState_t state, stateNext;
  logic cmdWrite;

  assign cmdWrite = regWrEn && cmdBit;

  always_comb begin
    stateNext = state;
    unique case (state)
      SND_IDLE: if (cmdWrite) stateNext = SND_PEND;
      SND_PEND: if (frameEnd) stateNext = SND_SEND;
      SND_SEND: if (frameEnd) stateNext = SND_IDLE;
      default:  stateNext = SND_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SND_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.busy       = (state != SND_IDLE);
    strobe.sendActive = (state == SND_SEND);
    strobe.latchTx    = (state == SND_PEND) && frameEnd;
  end

  // R5
  cmd_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !strobe.busy) |=> strobe.busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !frameEnd) |=> strobe.busy);

  // R6
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sendActive && frameEnd) |=> !strobe.busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sendActive && !frameEnd) |=> strobe.sendActive);
endmodule

// File: rtl/codec_gpio_dp.sv
module codec_gpio_dp
  import codec_gpio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               frameEnd,
  input  logic [N_CODEC-1:0] rxIntBits,
  input  ctrlStrobe_t        strobe,
  output logic [REG_W-1:0]   regRdData,
  output logic [GP_W-1:0]    txSlotData,
  output logic               txSlotValid,
  output logic               gpioIrq
);
  localparam logic [REG_W-1:0] WR_MASK =
      ({{(REG_W-DAT_LSB){1'b1}}, {DAT_LSB{1'b0}}}) |
      ({{(REG_W-N_CODEC){1'b0}}, {N_CODEC{1'b1}}} << EN_LSB);

  logic [REG_W-1:0]   hostReg;
  logic [N_CODEC-1:0] intStat;
  logic [N_CODEC-1:0] irqTerm;
  logic [GP_W-1:0]    txSnap;
  logic [REG_W-1:0]   statWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hostReg <= '0;
    else if (regWrEn) hostReg <= (regWrData & WR_MASK) | (hostReg & ~WR_MASK);
  end

  for (genvar c = 0; c < N_CODEC; c++) begin : g_codec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         intStat[c] <= 1'b0;
      else if (frameEnd) intStat[c] <= rxIntBits[c];
    end
    assign irqTerm[c] = intStat[c] & hostReg[EN_LSB + c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txSnap <= '0;
    else if (strobe.latchTx) txSnap <= hostReg[DAT_LSB +: GP_W];
  end

  always_comb begin
    statWord = '0;
    statWord[ST_LSB +: N_CODEC] = intStat;
    statWord[CMD_BIT] = strobe.busy;
  end

  assign regRdData   = hostReg | statWord;
  assign txSlotData  = txSnap;
  assign txSlotValid = strobe.sendActive;
  assign gpioIrq     = |irqTerm;

  // R2
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(intStat));

  // R7
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sendActive && !frameEnd) |=> $stable(txSnap));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[0] == 1'b0) && (regRdData[14:5] == '0));
endmodule

// File: rtl/codec_gpio_slot.sv
module codec_gpio_slot
  import codec_gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              frameEnd,
  input  logic              rxGpioIntPri,
  input  logic              rxGpioIntSec,
  output logic [GP_W-1:0]   txSlotData,
  output logic              txSlotValid,
  output logic              gpioIrq
);
  ctrlStrobe_t strobe;

  codec_gpio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .cmdBit   (regWrData[CMD_BIT]),
    .frameEnd (frameEnd),
    .strobe   (strobe)
  );

  codec_gpio_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .frameEnd    (frameEnd),
    .rxIntBits   ({rxGpioIntSec, rxGpioIntPri}),
    .strobe      (strobe),
    .regRdData   (regRdData),
    .txSlotData  (txSlotData),
    .txSlotValid (txSlotValid),
    .gpioIrq     (gpioIrq)
  );
endmodule

// File: tb/codec_gpio_slot_bench.sv
module codec_gpio_slot_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        frameEnd = 1'b0;
  logic        rxGpioIntPri = 1'b0;
  logic        rxGpioIntSec = 1'b0;
  logic [15:0] txSlotData;
  logic        txSlotValid;
  logic        gpioIrq;

  int errors = 0;
  int checks = 0;
  int sendFrames = 0;
  string curReq = "R1";

  // behavioural model state
  int          mPhase = 0;   // 0 idle, 1 waiting, 2 sending
  bit          mSt1 = 0, mSt2 = 0, mEn1 = 0, mEn2 = 0;
  bit [15:0]   mData = 0, mSnap = 0;
  bit          prevValid = 0;

  always #10 clk = ~clk;

  codec_gpio_slot u_codec_gpio_slot (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .frameEnd(frameEnd), .rxGpioIntPri(rxGpioIntPri),
    .rxGpioIntSec(rxGpioIntSec), .txSlotData(txSlotData),
    .txSlotValid(txSlotValid), .gpioIrq(gpioIrq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead();
    logic [31:0] r = '0;
    r[31:16] = mData;
    r[15] = (mPhase != 0);
    r[4] = mEn2; r[3] = mEn1; r[2] = mSt2; r[1] = mSt1;
    return r;
  endfunction

  task automatic compareAll();
    check(curReq, "regRdData", regRdData, mRead());
    check(curReq, "gpioIrq", {31'b0, gpioIrq}, {31'b0, (mSt1 & mEn1) | (mSt2 & mEn2)});
    check(curReq, "txSlotValid", {31'b0, txSlotValid}, {31'b0, mPhase == 2});
    check(curReq, "txSlotData", {16'b0, txSlotData}, {16'b0, mSnap});
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit wr, logic [31:0] wd, bit fe, bit a, bit b);
    int oldPhase;
    regWrEn = wr; regWrData = wd; frameEnd = fe;
    rxGpioIntPri = a; rxGpioIntSec = b;
    @(posedge clk);
    oldPhase = mPhase;
    if (rstN) begin
      if (fe) begin
        mSt1 = a; mSt2 = b;
        if (oldPhase == 1) begin mPhase = 2; mSnap = mData; end
        else if (oldPhase == 2) mPhase = 0;
      end
      if (wr) begin
        mEn1 = wd[3]; mEn2 = wd[4]; mData = wd[31:16];
        if (wd[15] && oldPhase == 0) mPhase = 1;
      end
    end
    @(negedge clk);
    compareAll();
    if (txSlotValid && !prevValid) sendFrames++;
    prevValid = txSlotValid;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  task automatic frameTick(bit a, bit b);
    step(0, '0, 1, a, b);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    curReq = "R1";
    compareAll();
    idle(2);
    rstN = 1'b1;
    idle(2);
    check("R1", "read after reset", regRdData, 32'h0);

    // R2 / R3 / R4: capture and enables under several patterns
    curReq = "R3";
    step(1, 32'h0000_0018, 0, 0, 0);
    check("R3", "enable readback", regRdData & 32'h18, 32'h18);
    curReq = "R2";
    frameTick(1, 0); idle(3);
    check("R4", "irq primary", {31'b0, gpioIrq}, 32'd1);
    frameTick(0, 1); idle(1);
    frameTick(1, 1); idle(1);
    step(0, '0, 0, 0, 1);           // rx changes without frame pulse: no effect
    check("R2", "hold between frames", regRdData & 32'h6, 32'h6);
    curReq = "R4";
    step(1, 32'h0000_0008, 0, 0, 0); // primary only enabled
    frameTick(0, 1); idle(1);
    check("R4", "masked secondary", {31'b0, gpioIrq}, 32'd0);
    step(1, 32'h0000_0010, 0, 0, 0);
    check("R4", "secondary enabled", {31'b0, gpioIrq}, 32'd1);
    step(1, 32'h0000_0006, 0, 0, 0); // bits 1,2 not writable
    check("R2", "status not writable", regRdData & 32'h6, 32'h4);
    frameTick(0, 0); idle(1);

    // R9 / R10 / R11: reserved bits, data field, command bit clear
    curReq = "R9";
    step(1, 32'hFFFF_7FE7, 0, 0, 0);
    check("R9", "reserved zero", regRdData & 32'h0000_7FE1, 32'h0);
    check("R10", "data readback", regRdData[31:16], 32'hFFFF);
    check("R11", "no busy on cmd=0", {31'b0, regRdData[15]}, 32'd0);
    curReq = "R11";
    frameTick(0, 0); frameTick(0, 0); idle(1);

    // R5 / R6 / R7: basic send
    curReq = "R5";
    sendFrames = 0;
    step(1, 32'hA5C3_8000, 0, 0, 0);
    check("R5", "busy after cmd", {31'b0, regRdData[15]}, 32'd1);
    curReq = "R6";
    idle(3);
    frameTick(0, 0);
    check("R6", "valid in send frame", {31'b0, txSlotValid}, 32'd1);
    curReq = "R7";
    check("R7", "tx data", {16'b0, txSlotData}, 32'h0000_A5C3);
    // R10 data write while busy, R7 snapshot unaffected, R8 command ignored
    curReq = "R8";
    step(1, 32'h1234_8000, 0, 0, 0);
    check("R7", "snapshot stable", {16'b0, txSlotData}, 32'h0000_A5C3);
    check("R10", "data write while busy", regRdData[31:16], 32'h1234);
    idle(4);
    frameTick(0, 0);
    check("R6", "busy cleared", {31'b0, regRdData[15]}, 32'd0);
    idle(2);
    frameTick(0, 0); frameTick(0, 0);
    check("R8", "one send frame", sendFrames, 1);

    // command in pending wait ignored, command on frame pulse
    curReq = "R8";
    sendFrames = 0;
    step(1, 32'h0F0F_8000, 0, 0, 0);
    step(1, 32'hBEEF_8000, 0, 0, 0);  // while pending: data updates only
    frameTick(0, 0);
    check("R7", "latest data sent", {16'b0, txSlotData}, 32'h0000_BEEF);
    step(1, 32'h7777_8000, 1, 0, 0);  // cmd on closing pulse: busy, ignored
    idle(2);
    frameTick(0, 0); frameTick(0, 0);
    check("R8", "no restart", sendFrames, 1);
    curReq = "R5";
    sendFrames = 0;
    step(1, 32'h4242_8000, 1, 1, 0);  // idle cmd coincident with frame end
    check("R6", "wait before send", {31'b0, txSlotValid}, 32'd0);
    idle(2);
    frameTick(0, 0);
    check("R6", "send after next pulse", {31'b0, txSlotValid}, 32'd1);
    frameTick(0, 0);
    idle(1);
    check("R6", "sent once", sendFrames, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule